// File: doc/BRIEF.md
# Fixed-Point Time-of-Day Counter

This block keeps a 64-bit system time that grows by a programmable increment on every cycle of its timing clock. The low bits of the count are a binary fraction of a nanosecond. A right shift by a fixed amount, chosen by the link speed, turns the raw count into whole nanoseconds. The shifted value is driven on an output next to the raw count. A large increment scaled this way lets software trim the clock frequency in very small steps. Software does that by rewriting the increment.

Software reaches the block through a small word-wide register port. It can write the increment and load or clear either half of the time. It can read the time as two 32-bit halves. Reading the low half captures the high half in a shadow register, so the two halves that software reads always belong to the same instant.

A two-bit speed input selects the default increment and the nanosecond shift. A parameter selects one of two variants:
- the full variant, with a 31-bit increment;
- the reduced variant, with a 24-bit increment whose defaults are scaled down by 7 bits.

Top module: `tod_counter`

## Requirements
- R1: During and right after reset the time is zero and the read data is zero. The increment holds the default for the speed code present at reset.
- R2: On every cycle with no time write, the time becomes the old time plus the increment, modulo 2^64. Carry ripples from the low half into the high half.
- R3: Speed codes 0 (10G) and 3 (no link) give a default increment of 0x66666666 and a shift of 28. Code 1 (1G) gives 0x40000000 and shift 24. Code 2 (100M) gives 0x50000000 and shift 21. In the reduced variant each default increment is shifted right by 7 and each shift is 7 lower.
- R4: After each clock edge the shift output equals the shift for the speed code sampled at that edge. The nanosecond output equals the time shifted right by the shift output.
- R5: When the speed code differs from the previous one, the default increment for the new code is loaded at that edge. The time still advances by the old increment in that cycle.
- R6: A write to address 2 stores the low 31 bits (full) or 24 bits (reduced) of the write data as the increment. The new value is used from the next cycle on, and the time still advances by the old increment in the write cycle. If the write falls in the same cycle as a speed change, the written value wins.
- R7: Reading address 2 returns the increment zero-extended in the full variant. In the reduced variant it returns the increment with bit 24 set and bits 31:25 clear.
- R8: A write to address 0 replaces time bits 31:0, and a write to address 1 replaces bits 63:32. The other half is kept, and the time does not advance in that cycle. Writing zero to address 0 and then to address 1 in back-to-back cycles leaves the time at zero.
- R9: Reading address 0 returns time bits 31:0 as they were before the edge and copies bits 63:32 into a shadow. Reading address 1 returns the shadow, not the live high half.
- R10: Read data appears one cycle after the read strobe and holds until the next read. Reads never change the time. Address 3 reads as zero, and a write to address 3 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock |
| rstN | input | 1 | Synchronous reset, active low |
| speedSel | input | 2 | Link speed code: 0 10G, 1 1G, 2 100M, 3 no link |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 2 | Register address: 0 time low, 1 time high, 2 increment |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, valid one cycle after the read strobe |
| sysTime | output | 64 | Raw fixed-point time |
| nsTime | output | 64 | Time in nanoseconds (raw time shifted right) |
| nsShift | output | 6 | Current raw-to-nanosecond shift |

## Verification
Two events can land on the same edge: a change of the speed code and a software write of the increment. Both want to load the increment register. The bench changes the speed input in the same cycle that it writes an increment. It expects the written value to be read back, the shift to follow the new speed, and the time of that cycle to have grown by the old increment. A low-half read in the same cycle as a low-half write is also provoked; the read must return the value from before the write.

// File: rtl/tod_pkg.sv
package tod_pkg;

  localparam int FULL_INC_W    = 31;
  localparam int REDUCED_INC_W = 24;
  localparam int PERIOD_BIT    = 24;

  localparam logic [30:0] BASE_INC_10G  = 31'h6666_6666;
  localparam logic [30:0] BASE_INC_1G   = 31'h4000_0000;
  localparam logic [30:0] BASE_INC_100M = 31'h5000_0000;

  localparam int BASE_SHIFT_10G  = 28;
  localparam int BASE_SHIFT_1G   = 24;
  localparam int BASE_SHIFT_100M = 21;

  typedef enum logic [1:0] {
    SPD_10G    = 2'd0,
    SPD_1G     = 2'd1,
    SPD_100M   = 2'd2,
    SPD_NOLINK = 2'd3
  } speed_e;

  localparam logic [1:0] ADDR_TIME_LO = 2'd0;
  localparam logic [1:0] ADDR_TIME_HI = 2'd1;
  localparam logic [1:0] ADDR_INC     = 2'd2;

  typedef struct packed {
    logic wrLo;
    logic wrHi;
    logic wrInc;
    logic rdLo;
    logic rdHi;
    logic rdInc;
    logic rdNone;
    logic speedLoad;
  } strobes_t;

endpackage

// File: rtl/tod_ctrl.sv
module tod_ctrl
  import tod_pkg::*;
#(
  parameter int INC_W = FULL_INC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       speedSel,
  input  logic             regWrEn,
  input  logic             regRdEn,
  input  logic [1:0]       regAddr,
  output strobes_t         stb,
  output logic [INC_W-1:0] speedDefInc,
  output logic [5:0]       shiftCur
);

  localparam int DROP = FULL_INC_W - INC_W;

  localparam logic [INC_W-1:0] DEF_10G  = INC_W'(BASE_INC_10G  >> DROP);
  localparam logic [INC_W-1:0] DEF_1G   = INC_W'(BASE_INC_1G   >> DROP);
  localparam logic [INC_W-1:0] DEF_100M = INC_W'(BASE_INC_100M >> DROP);

  localparam logic [5:0] SH_10G  = 6'(BASE_SHIFT_10G  - DROP);
  localparam logic [5:0] SH_1G   = 6'(BASE_SHIFT_1G   - DROP);
  localparam logic [5:0] SH_100M = 6'(BASE_SHIFT_100M - DROP);

  logic [1:0] speedQ;
  logic [5:0] shiftNext;

  always_comb begin
    case (speed_e'(speedSel))
      SPD_1G: begin
        speedDefInc = DEF_1G;
        shiftNext   = SH_1G;
      end
      SPD_100M: begin
        speedDefInc = DEF_100M;
        shiftNext   = SH_100M;
      end
      default: begin
        speedDefInc = DEF_10G;
        shiftNext   = SH_10G;
      end
    endcase
  end

  always_comb begin
    stb.wrLo      = regWrEn && (regAddr == ADDR_TIME_LO);
    stb.wrHi      = regWrEn && (regAddr == ADDR_TIME_HI);
    stb.wrInc     = regWrEn && (regAddr == ADDR_INC);
    stb.rdLo      = regRdEn && (regAddr == ADDR_TIME_LO);
    stb.rdHi      = regRdEn && (regAddr == ADDR_TIME_HI);
    stb.rdInc     = regRdEn && (regAddr == ADDR_INC);
    stb.rdNone    = regRdEn && (regAddr == 2'd3);
    stb.speedLoad = (speedSel != speedQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      speedQ   <= speedSel;
      shiftCur <= shiftNext;
    end else if (stb.speedLoad) begin
      speedQ   <= speedSel;
      shiftCur <= shiftNext;
    end
  end

endmodule

// File: rtl/tod_datapath.sv
module tod_datapath
  import tod_pkg::*;
#(
  parameter bit REDUCED = 1'b0,
  parameter int INC_W   = FULL_INC_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobes_t         stb,
  input  logic [31:0]      wrData,
  input  logic [INC_W-1:0] speedDefInc,
  input  logic [5:0]       shiftCur,
  output logic [63:0]      sysTime,
  output logic [63:0]      nsTime,
  output logic [INC_W-1:0] incCur,
  output logic [31:0]      rdData
);

  logic [63:0]      timeReg;
  logic [INC_W-1:0] incReg;
  logic [31:0]      shadowHi;
  logic [31:0]      incView;

  // time accumulator: a half write freezes the other half for that cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      timeReg <= '0;
    end else if (stb.wrLo) begin
      timeReg[31:0] <= wrData;
    end else if (stb.wrHi) begin
      timeReg[63:32] <= wrData;
    end else begin
      timeReg <= timeReg + 64'(incReg);
    end
  end

  // software write wins over a speed-driven reload
  always_ff @(posedge clk) begin
    if (!rstN) begin
      incReg <= speedDefInc;
    end else if (stb.wrInc) begin
      incReg <= wrData[INC_W-1:0];
    end else if (stb.speedLoad) begin
      incReg <= speedDefInc;
    end
  end

  generate
    if (REDUCED) begin : g_viewReduced
      always_comb incView = 32'(incReg) | (32'd1 << PERIOD_BIT);
    end else begin : g_viewFull
      always_comb incView = 32'(incReg);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shadowHi <= '0;
      rdData   <= '0;
    end else begin
      if (stb.rdLo) begin
        shadowHi <= timeReg[63:32];
        rdData   <= timeReg[31:0];
      end else if (stb.rdHi) begin
        rdData <= shadowHi;
      end else if (stb.rdInc) begin
        rdData <= incView;
      end else if (stb.rdNone) begin
        rdData <= '0;
      end
    end
  end

  assign sysTime = timeReg;
  assign nsTime  = timeReg >> shiftCur;
  assign incCur  = incReg;

endmodule

// File: rtl/tod_counter.sv
module tod_counter
  import tod_pkg::*;
#(
  parameter bit REDUCED = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [1:0]  speedSel,
  input  logic        regWrEn,
  input  logic        regRdEn,
  input  logic [1:0]  regAddr,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic [63:0] sysTime,
  output logic [63:0] nsTime,
  output logic [5:0]  nsShift
);

  localparam int INC_W = REDUCED ? REDUCED_INC_W : FULL_INC_W;

  strobes_t         stb;
  logic [INC_W-1:0] speedDefInc;
  logic [INC_W-1:0] incCur;

  tod_ctrl #(.INC_W(INC_W)) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .speedSel   (speedSel),
    .regWrEn    (regWrEn),
    .regRdEn    (regRdEn),
    .regAddr    (regAddr),
    .stb        (stb),
    .speedDefInc(speedDefInc),
    .shiftCur   (nsShift)
  );

  tod_datapath #(.REDUCED(REDUCED), .INC_W(INC_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .wrData     (regWrData),
    .speedDefInc(speedDefInc),
    .shiftCur   (nsShift),
    .sysTime    (sysTime),
    .nsTime     (nsTime),
    .incCur     (incCur),
    .rdData     (regRdData)
  );

endmodule

// File: rtl/tod_counter_chk.sv
module tod_counter_chk #(
  parameter bit REDUCED = 1'b0
) (
  input logic        clk,
  input logic        rstN,
  input logic [1:0]  speedSel,
  input logic        regWrEn,
  input logic        regRdEn,
  input logic [1:0]  regAddr,
  input logic [31:0] regWrData,
  input logic [31:0] regRdData,
  input logic [63:0] sysTime,
  input logic [5:0]  nsShift,
  input logic [(REDUCED ? 24 : 31)-1:0] incCur
);

  localparam int IW   = REDUCED ? 24 : 31;
  localparam int DROP = 31 - IW;

  function automatic logic [5:0] shiftFor(input logic [1:0] spd);
    case (spd)
      2'd1:    shiftFor = 6'(24 - DROP);
      2'd2:    shiftFor = 6'(21 - DROP);
      default: shiftFor = 6'(28 - DROP);
    endcase
  endfunction

  logic [63:0] incExt;
  assign incExt = 64'(incCur);

  logic timeWr;
  assign timeWr = regWrEn && (regAddr[1] == 1'b0);

  assert_time_advance_R2: assert property (@(posedge clk) disable iff (!rstN)
    !timeWr |=> sysTime == $past(sysTime) + $past(incExt));

  assert_lo_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd0) |=>
      (sysTime[31:0] == $past(regWrData)) && (sysTime[63:32] == $past(sysTime[63:32])));

  assert_hi_write_R8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd1) |=>
      (sysTime[63:32] == $past(regWrData)) && (sysTime[31:0] == $past(sysTime[31:0])));

  assert_inc_write_R6: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr == 2'd2) |=> incCur == $past(regWrData[IW-1:0]));

  assert_read_lo_R9: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr == 2'd0) |=> regRdData == $past(sysTime[31:0]));

  assert_read_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    !regRdEn |=> $stable(regRdData));

  assert_shift_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> nsShift == shiftFor($past(speedSel)));

endmodule

bind tod_counter tod_counter_chk #(.REDUCED(REDUCED)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .speedSel (speedSel),
  .regWrEn  (regWrEn),
  .regRdEn  (regRdEn),
  .regAddr  (regAddr),
  .regWrData(regWrData),
  .regRdData(regRdData),
  .sysTime  (sysTime),
  .nsShift  (nsShift),
  .incCur   (incCur)
);

// File: tb/tod_counter_tb.sv
module tod_counter_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  speedSel = 2'd1;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [1:0]  regAddr = 2'd0;
  logic [31:0] regWrData = '0;

  logic [31:0] rdData, rdDataR;
  logic [63:0] sysTime, sysTimeR, nsTime, nsTimeR;
  logic [5:0]  nsShift, nsShiftR;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  tod_counter #(.REDUCED(1'b0)) u_dut (
    .clk(clk), .rstN(rstN), .speedSel(speedSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(rdData), .sysTime(sysTime), .nsTime(nsTime), .nsShift(nsShift));

  tod_counter #(.REDUCED(1'b1)) u_dutReduced (
    .clk(clk), .rstN(rstN), .speedSel(speedSel), .regWrEn(regWrEn),
    .regRdEn(regRdEn), .regAddr(regAddr), .regWrData(regWrData),
    .regRdData(rdDataR), .sysTime(sysTimeR), .nsTime(nsTimeR), .nsShift(nsShiftR));

  // reference model, full (no suffix) and reduced (R suffix)
  logic [63:0] mT, mTR, mInc, mIncR;
  logic [31:0] mSh, mShR, expRd, expRdR;
  logic [5:0]  mShift, mShiftR;
  logic [1:0]  mSpd;

  function automatic logic [63:0] defInc(input logic [1:0] spd, input bit red);
    logic [63:0] v;
    case (spd)
      2'd1:    v = 64'h4000_0000;
      2'd2:    v = 64'h5000_0000;
      default: v = 64'h6666_6666;
    endcase
    return red ? (v >> 7) : v;
  endfunction

  function automatic logic [5:0] defShift(input logic [1:0] spd, input bit red);
    int s;
    case (spd)
      2'd1:    s = 24;
      2'd2:    s = 21;
      default: s = 28;
    endcase
    return 6'(red ? s - 7 : s);
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic checkAll();
    chk("R2 full time", sysTime, mT);
    chk("R2 reduced time", sysTimeR, mTR);
    chk("R4 full shift", 64'(nsShift), 64'(mShift));
    chk("R4 reduced shift", 64'(nsShiftR), 64'(mShiftR));
    chk("R4 full ns", nsTime, mT >> mShift);
    chk("R4 reduced ns", nsTimeR, mTR >> mShiftR);
    chk("R10 full read data", 64'(rdData), 64'(expRd));
    chk("R10 reduced read data", 64'(rdDataR), 64'(expRdR));
  endtask

  // one cycle: drive at negedge, model at posedge, check at next negedge
  task automatic cyc(input logic we, input logic re, input logic [1:0] a, input logic [31:0] d);
    regWrEn = we; regRdEn = re; regAddr = a; regWrData = d;
    @(posedge clk);
    #1;
    if (re) begin
      case (a)
        2'd0: begin
          expRd = mT[31:0];   mSh = mT[63:32];
          expRdR = mTR[31:0]; mShR = mTR[63:32];
        end
        2'd1: begin expRd = mSh; expRdR = mShR; end
        2'd2: begin expRd = mInc[31:0]; expRdR = mIncR[31:0] | 32'h0100_0000; end
        default: begin expRd = '0; expRdR = '0; end
      endcase
    end
    if (we && a == 2'd0) begin
      mT[31:0] = d; mTR[31:0] = d;
    end else if (we && a == 2'd1) begin
      mT[63:32] = d; mTR[63:32] = d;
    end else begin
      mT = mT + mInc; mTR = mTR + mIncR;
    end
    if (speedSel != mSpd) begin
      mShift = defShift(speedSel, 1'b0);
      mShiftR = defShift(speedSel, 1'b1);
      if (!(we && a == 2'd2)) begin
        mInc = defInc(speedSel, 1'b0);
        mIncR = defInc(speedSel, 1'b1);
      end
      mSpd = speedSel;
    end
    if (we && a == 2'd2) begin
      mInc = 64'(d[30:0]);
      mIncR = 64'(d[23:0]);
    end
    @(negedge clk);
    regWrEn = 1'b0; regRdEn = 1'b0;
    checkAll();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(1'b0, 1'b0, 2'd0, 32'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset with 1G selected
    repeat (3) @(posedge clk);
    @(negedge clk);
    mT = '0; mTR = '0; mSh = '0; mShR = '0; expRd = '0; expRdR = '0;
    mSpd = speedSel;
    mInc = defInc(speedSel, 1'b0); mIncR = defInc(speedSel, 1'b1);
    mShift = defShift(speedSel, 1'b0); mShiftR = defShift(speedSel, 1'b1);
    chk("R1 time zero in reset", sysTime, 64'd0);
    chk("R1 read data zero in reset", 64'(rdData), 64'd0);
    rstN = 1'b1;
    chk("R1 time zero after release", sysTime, 64'd0);
    cyc(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R1 default 1G increment", 64'(rdData), 64'h4000_0000);
    chk("R7 reduced 1G increment view", 64'(rdDataR), 64'h0180_0000);

    // R3 R5: sweep all speed codes
    for (int s = 0; s < 4; s++) begin
      speedSel = 2'(s);
      cyc(1'b0, 1'b0, 2'd0, 32'd0);
      cyc(1'b0, 1'b1, 2'd2, 32'd0);
      chk("R3 default increment", 64'(rdData), defInc(2'(s), 1'b0));
      chk("R3 reduced default increment", 64'(rdDataR & 32'h00FF_FFFF), defInc(2'(s), 1'b1));
      idle(6);
    end
    speedSel = 2'd0;
    idle(2);

    // R6 R7: increment writes with masking
    cyc(1'b1, 1'b0, 2'd2, 32'hFFFF_FFFF);
    idle(3);
    cyc(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R7 full increment view", 64'(rdData), 64'h7FFF_FFFF);
    chk("R7 reduced increment view", 64'(rdDataR), 64'h01FF_FFFF);

    // R6: increment write coinciding with a speed change
    speedSel = 2'd2;
    cyc(1'b1, 1'b0, 2'd2, 32'h0123_4567);
    idle(2);
    cyc(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R6 write wins over speed reload", 64'(rdData), 64'h0123_4567);
    chk("R6 shift still follows speed", 64'(nsShift), 64'd21);

    // R8 R2: load near the top and wrap through zero
    speedSel = 2'd0;
    cyc(1'b0, 1'b0, 2'd0, 32'd0);
    cyc(1'b1, 1'b0, 2'd0, 32'hFFFF_FFF0);
    cyc(1'b1, 1'b0, 2'd1, 32'hFFFF_FFFF);
    chk("R8 loaded value", sysTime, 64'hFFFF_FFFF_FFFF_FFF0);
    idle(4);
    chk("R2 wrapped past 2^64", sysTime, 64'hFFFF_FFFF_FFFF_FFF0 + 64'h6666_6666 * 4);

    // R8: clear with back-to-back zero writes
    cyc(1'b1, 1'b0, 2'd0, 32'd0);
    cyc(1'b1, 1'b0, 2'd1, 32'd0);
    chk("R8 cleared", sysTime, 64'd0);

    // R9: shadow keeps the high half of the low read
    cyc(1'b1, 1'b0, 2'd0, 32'hF000_0000);
    cyc(1'b1, 1'b0, 2'd1, 32'd5);
    cyc(1'b0, 1'b1, 2'd0, 32'd0);
    idle(8);
    cyc(1'b0, 1'b1, 2'd1, 32'd0);
    chk("R9 shadow high half", 64'(rdData), 64'd5);

    // R9: read low in the same cycle as a low write returns the old value
    cyc(1'b1, 1'b1, 2'd0, 32'h1234_5678);
    idle(1);

    // R10: address 3 ignored on write, reads zero
    cyc(1'b1, 1'b0, 2'd3, 32'hDEAD_BEEF);
    cyc(1'b0, 1'b1, 2'd3, 32'd0);
    chk("R10 unused address reads zero", 64'(rdData), 64'd0);
    cyc(1'b0, 1'b1, 2'd2, 32'd0);
    chk("R10 unused write leaves increment", 64'(rdData), 64'h6666_6666);

    // R2 R4: sweep increments and speeds
    for (int k = 0; k < 16; k++) begin
      speedSel = 2'(k % 4);
      cyc(1'b1, 1'b0, 2'd2, 32'h0F0F_0F11 * (k + 1) + 32'h3C5);
      idle(20);
      cyc(1'b0, 1'b1, 2'd0, 32'd0);
      cyc(1'b0, 1'b1, 2'd1, 32'd0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule